// File: doc/BRIEF.md
# Indirect Branch Landing Checker

This block sits beside the retirement stage of a processor and watches the in-order stream of retired instructions. Each instruction brings a transfer-type tag, its first four opcode bytes, a flag for 64-bit or 32-bit mode, and a flag saying whether it lies in a legacy code region. When checking is enabled, any indirect call or indirect jump arms a one-bit tracking state. The next valid instruction is then the landing site, and it must be the end-branch marker for the current mode.

A correct marker clears tracking quietly. A landing in a legacy region also clears tracking and raises no fault. Any other landing raises a one-cycle control-protection fault pulse and clears tracking, so each bad landing is reported once. Decoding beyond the four-byte compare is left to the core, and so is the delivery of the fault.

Top module: `ibt_landing_chk`

## Requirements
- R1: After reset, `track_o` and `fault_o` are both 0.
- R2: A valid instruction with `br_kind_i` = 3 (indirect call or jump) and `chk_en_i` = 1 sets `track_o` on the next cycle. This holds even when that instruction is itself being checked as a landing site.
- R3: A valid instruction with `br_kind_i` = 0 (plain), 1 (direct call or jump) or 2 (return) leaves `track_o` at 0 on the next cycle.
- R4: While tracking in 64-bit mode (`mode64_i` = 1), a valid instruction whose bytes are F3 0F 1E FA clears tracking with no fault. Byte 0 sits in bits 7:0 and byte 3 in bits 31:24.
- R5: In 32-bit mode (`mode64_i` = 0), the accepted marker is F3 0F 1E FB. The 64-bit marker is rejected in 32-bit mode, and the 32-bit marker is rejected in 64-bit mode.
- R6: While tracking, a valid instruction that is not the marker for the mode and has `legacy_i` = 0 drives `fault_o` to 1 on the next cycle, for that cycle only, and clears tracking.
- R7: When not tracking, a marker instruction has no effect: no fault, and tracking stays clear.
- R8: While tracking, a valid landing instruction with `legacy_i` = 1 clears tracking and raises no fault, whatever its bytes.
- R9: A cycle with `instr_valid_i` = 0 and checking enabled raises no fault and leaves `track_o` unchanged.
- R10: With `chk_en_i` = 0, `fault_o` is 0 and `track_o` is 0 on the next cycle, and indirect transfers do not arm tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid_i | input | 1 | A retired instruction is present this cycle |
| br_kind_i | input | 2 | 0 plain, 1 direct, 2 return, 3 indirect call/jump |
| opc_bytes_i | input | 32 | First four opcode bytes, byte 0 in bits 7:0 |
| mode64_i | input | 1 | 1 for 64-bit mode, 0 for 32-bit mode |
| chk_en_i | input | 1 | Landing check enable |
| legacy_i | input | 1 | Instruction lies in a legacy code region |
| track_o | output | 1 | Tracking state: an indirect transfer awaits its landing |
| fault_o | output | 1 | One-cycle control-protection fault pulse |

## Verification
The bench builds the block with its default parameter, a four-byte opcode window, so the marker compare covers every byte of both markers. Directed sequences place a single wrong byte at each position of the marker, and pair each marker with the wrong mode. A long stream of mixed random traffic then brings within reach the corner cases a directed list misses. These include an indirect transfer that is also a bad landing site, runs of invalid cycles between a branch and its landing, and enable toggling in the middle of tracking.

// File: rtl/ibt_pkg.sv
package ibt_pkg;
  typedef enum logic [1:0] {
    BR_PLAIN    = 2'd0,
    BR_DIRECT   = 2'd1,
    BR_RETURN   = 2'd2,
    BR_INDIRECT = 2'd3
  } br_kind_e;

  // Expected landing-marker byte at position idx for the given mode.
  function automatic logic [7:0] marker_byte(input int idx, input logic mode64);
    case (idx)
      0:       marker_byte = 8'hF3;
      1:       marker_byte = 8'h0F;
      2:       marker_byte = 8'h1E;
      default: marker_byte = mode64 ? 8'hFA : 8'hFB;
    endcase
  endfunction
endpackage

// File: rtl/ibt_marker_match.sv
module ibt_marker_match #(
  parameter int OPC_BYTES = 4,
  localparam int OPC_W = 8 * OPC_BYTES
) (
  input  logic [OPC_W-1:0] opc_bytes_i,
  input  logic             mode64_i,
  output logic             hit_o
);
  logic [OPC_BYTES-1:0] byte_eq;

  for (genvar b = 0; b < OPC_BYTES; b++) begin : g_byte
    assign byte_eq[b] = (opc_bytes_i[8*b +: 8] == ibt_pkg::marker_byte(b, mode64_i));
  end

  assign hit_o = &byte_eq;
endmodule

// File: rtl/ibt_track_fsm.sv
module ibt_track_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic valid_i,
  input  logic indirect_i,
  input  logic hit_i,
  input  logic legacy_i,
  input  logic en_i,
  output logic track_o,
  output logic fault_o
);
  typedef enum logic {ST_IDLE = 1'b0, ST_TRACK = 1'b1} st_e;
  st_e  st_q, st_d;
  logic fault_d;
  logic landing;

  assign landing = valid_i && en_i && (st_q == ST_TRACK);

  always_comb begin
    st_d    = st_q;
    fault_d = 1'b0;
    if (!en_i) begin
      st_d = ST_IDLE;
    end else if (valid_i) begin
      fault_d = landing && !legacy_i && !hit_i;
      st_d    = indirect_i ? ST_TRACK : ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      fault_o <= 1'b0;
    end else begin
      st_q    <= st_d;
      fault_o <= fault_d;
    end
  end

  assign track_o = (st_q == ST_TRACK);
endmodule

// File: rtl/ibt_landing_chk.sv
module ibt_landing_chk #(
  parameter int OPC_BYTES = 4,
  localparam int OPC_W = 8 * OPC_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_valid_i,
  input  logic [1:0]       br_kind_i,
  input  logic [OPC_W-1:0] opc_bytes_i,
  input  logic             mode64_i,
  input  logic             chk_en_i,
  input  logic             legacy_i,
  output logic             track_o,
  output logic             fault_o
);
  logic marker_hit;
  logic is_indirect;

  assign is_indirect = (ibt_pkg::br_kind_e'(br_kind_i) == ibt_pkg::BR_INDIRECT);

  ibt_marker_match #(.OPC_BYTES(OPC_BYTES)) u_match (
    .opc_bytes_i (opc_bytes_i),
    .mode64_i    (mode64_i),
    .hit_o       (marker_hit)
  );

  ibt_track_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (instr_valid_i),
    .indirect_i (is_indirect),
    .hit_i      (marker_hit),
    .legacy_i   (legacy_i),
    .en_i       (chk_en_i),
    .track_o    (track_o),
    .fault_o    (fault_o)
  );
endmodule

// File: rtl/ibt_landing_chk_sva.sv
module ibt_landing_chk_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       instr_valid_i,
  input logic [1:0] br_kind_i,
  input logic       chk_en_i,
  input logic       legacy_i,
  input logic       marker_hit,
  input logic       track_o,
  input logic       fault_o
);
  // R2
  arm_indirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid_i && chk_en_i && br_kind_i == 2'd3) |=> track_o);

  // R3
  no_arm_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid_i && chk_en_i && br_kind_i != 2'd3) |=> !track_o);

  // R4
  marker_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid_i && track_o && marker_hit) |=> !fault_o);

  // R6
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> $past(track_o && instr_valid_i && chk_en_i && !legacy_i && !marker_hit));

  // R8
  legacy_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid_i && track_o && legacy_i) |=> !fault_o);

  // R9
  bubble_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_valid_i && chk_en_i) |=> ($stable(track_o) && !fault_o));

  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en_i |=> (!track_o && !fault_o));
endmodule

bind ibt_landing_chk ibt_landing_chk_sva u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .instr_valid_i (instr_valid_i),
  .br_kind_i     (br_kind_i),
  .chk_en_i      (chk_en_i),
  .legacy_i      (legacy_i),
  .marker_hit    (marker_hit),
  .track_o       (track_o),
  .fault_o       (fault_o)
);

// File: tb/tb_ibt_landing_chk.sv
module tb_ibt_landing_chk;
  localparam logic [31:0] MK64 = 32'hFA1E0FF3;
  localparam logic [31:0] MK32 = 32'hFB1E0FF3;

  logic clk = 1'b0;
  logic rst_n;
  logic v, m64, en, leg;
  logic [1:0]  kind;
  logic [31:0] bytes_in;
  logic track_o, fault_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 0;
  bit m_track = 0;

  always #10 clk = ~clk;

  ibt_landing_chk dut (
    .clk(clk), .rst_n(rst_n), .instr_valid_i(v), .br_kind_i(kind),
    .opc_bytes_i(bytes_in), .mode64_i(m64), .chk_en_i(en), .legacy_i(leg),
    .track_o(track_o), .fault_o(fault_o)
  );

  task automatic check(input string req, input logic act_t, act_f, exp_t, exp_f);
    n_tests++;
    if (act_t !== exp_t || act_f !== exp_f) begin
      n_fail++;
      $display("FAIL %s: track=%b fault=%b expected track=%b fault=%b",
               req, act_t, act_f, exp_t, exp_f);
    end
  endtask

  // One instruction-stream cycle, driven at negedge and checked at the next negedge.
  task automatic step(input logic iv, input logic [1:0] k, input logic [31:0] b,
                      input logic md, input logic e, input logic lg, input string req);
    bit exp_f, nxt;
    v = iv; kind = k; bytes_in = b; m64 = md; en = e; leg = lg;
    exp_f = iv && e && m_track && !lg && (b != (md ? MK64 : MK32));
    if (!e)       nxt = 0;
    else if (!iv) nxt = m_track;
    else          nxt = (k == 2'd3);
    @(posedge clk);
    @(negedge clk);
    m_track = nxt;
    check(req, track_o, fault_o, nxt, exp_f);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; v = 0; kind = 0; bytes_in = 0; m64 = 1; en = 1; leg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 reset", track_o, fault_o, 1'b0, 1'b0);

    // R2 then R4: 64-bit landing on marker
    step(1, 2'd3, 32'h0, 1, 1, 0, "R2 arm");
    step(1, 2'd0, MK64, 1, 1, 0, "R4 marker64 clears");
    // R3: direct, return and plain do not arm
    step(1, 2'd1, 32'h0, 1, 1, 0, "R3 direct");
    step(1, 2'd2, 32'h0, 1, 1, 0, "R3 return");
    step(1, 2'd0, 32'h12345678, 1, 1, 0, "R3 plain");
    // R7: marker when idle
    step(1, 2'd0, MK64, 1, 1, 0, "R7 idle marker");
    step(1, 2'd0, MK32, 0, 1, 0, "R7 idle marker32");
    // R6: a wrong byte at each position faults once
    for (int i = 0; i < 4; i++) begin
      step(1, 2'd3, 32'h0, 1, 1, 0, "R2 arm");
      step(1, 2'd0, MK64 ^ (32'h1 << (8*i)), 1, 1, 0, "R6 bad byte");
      step(1, 2'd0, 32'h0, 1, 1, 0, "R6 single pulse");
    end
    // R5: mode-dependent marker
    step(1, 2'd3, 32'h0, 0, 1, 0, "R2 arm");
    step(1, 2'd0, MK32, 0, 1, 0, "R5 marker32 ok");
    step(1, 2'd3, 32'h0, 0, 1, 0, "R2 arm");
    step(1, 2'd0, MK64, 0, 1, 0, "R5 marker64 rejected in 32-bit");
    step(1, 2'd3, 32'h0, 1, 1, 0, "R2 arm");
    step(1, 2'd0, MK32, 1, 1, 0, "R5 marker32 rejected in 64-bit");
    // R8: legacy bypass
    step(1, 2'd3, 32'h0, 1, 1, 0, "R2 arm");
    step(1, 2'd0, 32'hDEADBEEF, 1, 1, 1, "R8 legacy bypass");
    // R9: bubbles hold tracking
    step(1, 2'd3, 32'h0, 1, 1, 0, "R2 arm");
    step(0, 2'd0, 32'h0, 1, 1, 0, "R9 bubble");
    step(0, 2'd3, 32'h0, 1, 1, 0, "R9 bubble indirect");
    step(1, 2'd0, MK64, 1, 1, 0, "R9 landing after bubbles");
    // R6 and R2: an indirect that is a bad landing faults and rearms
    step(1, 2'd3, 32'h0, 1, 1, 0, "R2 arm");
    step(1, 2'd3, 32'h0, 1, 1, 0, "R6 fault and rearm");
    step(1, 2'd0, 32'h0, 1, 1, 0, "R6 second fault");
    // R10: disable
    step(1, 2'd3, 32'h0, 1, 1, 0, "R2 arm");
    step(0, 2'd0, 32'h0, 1, 0, 0, "R10 disable clears");
    step(1, 2'd3, 32'h0, 1, 0, 0, "R10 no arm when off");
    step(1, 2'd0, 32'h0, 1, 0, 0, "R10 no fault when off");

    // Mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r = $urandom;
      logic [31:0] b = r[3] ? (r[4] ? MK64 : MK32) : $urandom;
      step(r[0] | r[1], r[6:5], b, r[7], |r[10:8], (r[13:11] == 0), "R6 mixed");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule